// File: doc/BRIEF.md
# Math Coprocessor I/O Window Decoder

This block sits on a byte-wide I/O bus and answers a sixteen-address window that a legacy system keeps for a numeric coprocessor. It holds the coprocessor busy latch and the coprocessor error interrupt line. Two offsets in the window carry an action: one clears the busy latch and one issues a coprocessor reset pulse. The other offsets, including the ones used for opcode transfers, are not implemented. Writes to them are flagged as unclaimed. Reads are never supported in the window. A read is flagged and returns the all-ones value that marks an unused port.

Every byte-sized write that lands in the window drops the interrupt, whatever its offset and whether or not it is flagged. A write of any other size is flagged and has no other effect. The coprocessor raises the busy latch and the interrupt through a one-cycle busy-set input. The bus address, strobes and size qualifier are sampled on each clock. All responses are registered and appear one clock later. The write data carries no meaning for any action, so the block does not take a write-data input.

Top module: `mcw_window`

## Requirements
- R1: Only addresses BASE to BASE+15 (default 0x00F0 to 0x00FF) are claimed. An access outside the window leaves every output and every latch unchanged, and rd_data reads 0x00.
- R2: A byte write to window offset 0 clears cop_busy on the next clock. It wins over busy_set in the same cycle.
- R3: A byte write to window offset 1 drives cop_reset high for exactly the next clock only.
- R4: A byte write to any offset other than 0 and 1 drives acc_err high on the next clock. This covers the opcode-transfer offsets 8, 10 and 12. Offsets 0 and 1 never flag.
- R5: After any byte write in the window, irq_out is low on the next clock. This holds for flagged offsets too, and wins over busy_set in the same cycle.
- R6: A write in the window with io_byte low drives acc_err high on the next clock and leaves cop_busy, irq_out and cop_reset unchanged.
- R7: A read in the window (io_rd high, which takes precedence over io_wr) drives acc_err high and rd_data to 0xFF on the next clock and changes no latch. In every other cycle rd_data is 0x00.
- R8: A busy_set pulse sets cop_busy and irq_out on the next clock unless R2 or R5 overrides it.
- R9: A clock edge with rst high clears cop_busy, irq_out, cop_reset and acc_err and sets rd_data to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W (16) | I/O address |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_byte | input | 1 | High when the access is one byte wide |
| busy_set | input | 1 | Pulse from the coprocessor that sets the busy latch |
| rd_data | output | DATA_W (8) | Registered read return value |
| irq_out | output | 1 | Coprocessor error interrupt line |
| cop_reset | output | 1 | One-clock coprocessor reset pulse |
| acc_err | output | 1 | One-clock flag marking an unclaimed access |
| cop_busy | output | 1 | Busy latch state |

## Verification
All sixteen offsets get a byte write, so the two action offsets are told apart from every flagged one. Each flagged write is made with the interrupt already high, so the rule that any byte write drops the interrupt is separated from a rule that only the action offsets do. Same-cycle busy_set with a clear, with a flagged write and with a wrong-size write exposes the priority order. Reads, combined read-and-write strobes and addresses just outside both window edges show that the decode and the read-precedence rule leave state untouched.

// File: rtl/mcw_pkg.sv
package mcw_pkg;
  // Decoded meaning of the current bus cycle
  typedef struct packed {
    logic rd_hit;    // read in window
    logic wr_ok;     // byte write in window
    logic wr_bad;    // non-byte write in window
    logic do_clear;  // byte write to the clear offset
    logic do_reset;  // byte write to the reset offset
    logic unsup;     // byte write to an offset with no action
  } mcw_dec_t;
endpackage

// File: rtl/mcw_decode.sv
module mcw_decode
  import mcw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int OFF_W     = 4,
  parameter int BASE      = 'h00F0,
  parameter int CLEAR_OFF = 0,
  parameter int RESET_OFF = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              byte_sz,
  output mcw_dec_t          dec
);
  localparam int WIN  = 1 << OFF_W;
  localparam int TAGW = ADDR_W - OFF_W;
  localparam logic [TAGW-1:0] BASE_TAG = TAGW'(BASE >> OFF_W);

  // Per-offset action map built from the parameters
  logic [WIN-1:0] has_action;
  genvar g;
  generate
    for (g = 0; g < WIN; g++) begin : g_map
      assign has_action[g] = (g == CLEAR_OFF) || (g == RESET_OFF);
    end
  endgenerate

  logic              hit;
  logic [OFF_W-1:0]  off;

  always_comb begin
    hit = (addr[ADDR_W-1:OFF_W] == BASE_TAG);
    off = addr[OFF_W-1:0];
    dec.rd_hit   = hit && rd;
    dec.wr_ok    = hit && wr && !rd && byte_sz;
    dec.wr_bad   = hit && wr && !rd && !byte_sz;
    dec.do_clear = dec.wr_ok && (off == OFF_W'(CLEAR_OFF));
    dec.do_reset = dec.wr_ok && (off == OFF_W'(RESET_OFF));
    dec.unsup    = dec.wr_ok && !has_action[off];
  end
endmodule

// File: rtl/mcw_state.sv
module mcw_state
  import mcw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  mcw_dec_t dec,
  input  logic     busy_set,
  output logic     busy_q,
  output logic     irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (dec.do_clear)   busy_q <= 1'b0;
      else if (busy_set)  busy_q <= 1'b1;
      if (dec.wr_ok)      irq_q  <= 1'b0;
      else if (busy_set)  irq_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/mcw_resp.sv
module mcw_resp
  import mcw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  mcw_dec_t          dec,
  output logic [DATA_W-1:0] rd_q,
  output logic              err_q,
  output logic              rst_pulse_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q        <= '0;
      err_q       <= 1'b0;
      rst_pulse_q <= 1'b0;
    end else begin
      rd_q        <= dec.rd_hit ? '1 : '0;
      err_q       <= dec.rd_hit || dec.wr_bad || dec.unsup;
      rst_pulse_q <= dec.do_reset;
    end
  end
endmodule

// File: rtl/mcw_window.sv
module mcw_window
  import mcw_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int OFF_W     = 4,
  parameter int BASE      = 'h00F0,
  parameter int CLEAR_OFF = 0,
  parameter int RESET_OFF = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              io_byte,
  input  logic              busy_set,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out,
  output logic              cop_reset,
  output logic              acc_err,
  output logic              cop_busy
);
  mcw_dec_t dec;

  mcw_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .BASE(BASE),
    .CLEAR_OFF(CLEAR_OFF), .RESET_OFF(RESET_OFF)
  ) u_dec (
    .addr(io_addr), .rd(io_rd), .wr(io_wr), .byte_sz(io_byte), .dec(dec)
  );

  mcw_state u_state (
    .clk(clk), .rst(rst), .dec(dec), .busy_set(busy_set),
    .busy_q(cop_busy), .irq_q(irq_out)
  );

  mcw_resp #(.DATA_W(DATA_W)) u_resp (
    .clk(clk), .rst(rst), .dec(dec),
    .rd_q(rd_data), .err_q(acc_err), .rst_pulse_q(cop_reset)
  );
endmodule

// File: rtl/mcw_window_chk.sv
module mcw_window_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int OFF_W     = 4,
  parameter int BASE      = 'h00F0,
  parameter int CLEAR_OFF = 0,
  parameter int RESET_OFF = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              io_byte,
  input logic              busy_set,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_out,
  input logic              cop_reset,
  input logic              acc_err,
  input logic              cop_busy
);
  localparam int TAGW = ADDR_W - OFF_W;
  localparam logic [TAGW-1:0] BASE_TAG = TAGW'(BASE >> OFF_W);

  logic in_win, bwr;
  assign in_win = (io_addr[ADDR_W-1:OFF_W] == BASE_TAG);
  assign bwr    = in_win && io_wr && !io_rd && io_byte;

  // R2
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (bwr && io_addr[OFF_W-1:0] == OFF_W'(CLEAR_OFF)) |=> !cop_busy);
  // R3
  a_r3_reset_cause: assert property (@(posedge clk) disable iff (rst)
    cop_reset |-> $past(bwr && io_addr[OFF_W-1:0] == OFF_W'(RESET_OFF)));
  // R5
  a_r5_irq_drop: assert property (@(posedge clk) disable iff (rst)
    bwr |=> !irq_out);
  // R6
  a_r6_bad_size_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_win && io_wr && !io_rd && !io_byte && !busy_set)
      |=> (acc_err && $stable(cop_busy) && $stable(irq_out) && !cop_reset));
  // R7
  a_r7_read_flag: assert property (@(posedge clk) disable iff (rst)
    (in_win && io_rd) |=> (acc_err && rd_data == '1));
  // R1
  a_r1_outside_quiet: assert property (@(posedge clk) disable iff (rst)
    (!in_win && !busy_set) |=> (!acc_err && !cop_reset && rd_data == '0
                                && $stable(cop_busy) && $stable(irq_out)));
  // R9
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!cop_busy && !irq_out && !cop_reset && !acc_err));
endmodule

bind mcw_window mcw_window_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .BASE(BASE),
  .CLEAR_OFF(CLEAR_OFF), .RESET_OFF(RESET_OFF)
) u_chk (.*);

// File: tb/tb_mcw_window.sv
module tb_mcw_window;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0, io_byte = 1'b0, busy_set = 1'b0;
  logic [7:0]  rd_data;
  logic        irq_out, cop_reset, acc_err, cop_busy;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference model state
  bit       m_busy = 0, m_irq = 0, m_rstp = 0, m_err = 0;
  bit [7:0] m_rd = 8'h00;

  always #10 clk = ~clk;  // 50 MHz

  mcw_window dut (.*);

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_run();
  end

  // Apply one cycle of inputs, advance model at the edge, compare afterwards
  task automatic step(input string tag, input bit r, input logic [15:0] a,
                      input bit rd, input bit wr, input bit by, input bit bs);
    bit hit, rdv, wb, wbad;
    int off;
    rst = r; io_addr = a; io_rd = rd; io_wr = wr; io_byte = by; busy_set = bs;
    @(posedge clk);
    hit  = (a >= 16'h00F0) && (a <= 16'h00FF);
    off  = a - 16'h00F0;
    rdv  = hit && rd;
    wb   = hit && wr && !rd && by;
    wbad = hit && wr && !rd && !by;
    if (r) begin
      m_busy = 0; m_irq = 0; m_rstp = 0; m_err = 0; m_rd = 8'h00;
    end else begin
      if (wb && off == 0) m_busy = 0; else if (bs) m_busy = 1;
      if (wb) m_irq = 0; else if (bs) m_irq = 1;
      m_rstp = wb && off == 1;
      m_err  = rdv || wbad || (wb && off != 0 && off != 1);
      m_rd   = rdv ? 8'hFF : 8'h00;
    end
    @(negedge clk);
    vectors++;
    if (rd_data !== m_rd || irq_out !== m_irq || cop_reset !== m_rstp ||
        acc_err !== m_err || cop_busy !== m_busy) begin
      miscompares++;
      $display("FAIL %s addr=%h: actual rd=%h irq=%b rst=%b err=%b busy=%b expected rd=%h irq=%b rst=%b err=%b busy=%b",
               tag, a, rd_data, irq_out, cop_reset, acc_err, cop_busy,
               m_rd, m_irq, m_rstp, m_err, m_busy);
    end
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 16'h0000, 0, 0, 0, 0);
  endtask

  initial begin
    @(negedge clk);
    step("R9", 1, 16'h0000, 0, 0, 0, 0);
    step("R9", 1, 16'h00F0, 1, 0, 1, 1);
    idle("R9");
    // R8: busy_set raises latch and interrupt
    step("R8", 0, 16'h0000, 0, 0, 0, 1);
    idle("R8");
    // R2/R5: clear offset
    step("R2", 0, 16'h00F0, 0, 1, 1, 0);
    // R3: reset offset pulses once, busy stays, irq drops
    step("R8", 0, 16'h0000, 0, 0, 0, 1);
    step("R3", 0, 16'h00F1, 0, 1, 1, 0);
    idle("R3");
    // R4/R5: opcode-transfer offset with busy_set in the same cycle
    step("R5", 0, 16'h00F8, 0, 1, 1, 1);
    // every offset, each with the interrupt raised first
    for (int o = 0; o < 16; o++) begin
      step("R8", 0, 16'h0000, 0, 0, 0, 1);
      step("R4", 0, 16'h00F0 + 16'(o), 0, 1, 1, 0);
    end
    // R6: wrong-size writes change nothing
    step("R8", 0, 16'h0000, 0, 0, 0, 1);
    step("R6", 0, 16'h00F0, 0, 1, 0, 0);
    step("R6", 0, 16'h00F1, 0, 1, 0, 0);
    step("R6", 0, 16'h00F3, 0, 1, 0, 1);
    idle("R6");
    // R7: reads, including read with write strobe
    step("R7", 0, 16'h00F0, 1, 0, 1, 0);
    step("R7", 0, 16'h00FF, 1, 0, 0, 0);
    step("R7", 0, 16'h00F1, 1, 1, 1, 0);
    step("R7", 0, 16'h00F0, 1, 1, 1, 0);
    idle("R7");
    // R1: just outside both edges, and aliasing addresses
    step("R1", 0, 16'h00EF, 0, 1, 1, 0);
    step("R1", 0, 16'h0100, 0, 1, 1, 0);
    step("R1", 0, 16'h01F0, 1, 0, 1, 0);
    step("R1", 0, 16'h10F1, 0, 1, 1, 0);
    step("R1", 0, 16'h00EF, 1, 0, 0, 0);
    // R2: clear wins over busy_set in the same cycle
    step("R2", 0, 16'h00F0, 0, 1, 1, 1);
    // back-to-back reset offset writes
    step("R3", 0, 16'h00F1, 0, 1, 1, 0);
    step("R3", 0, 16'h00F1, 0, 1, 1, 0);
    idle("R3");
    // R9: reset while busy and interrupting
    step("R8", 0, 16'h0000, 0, 0, 0, 1);
    step("R9", 1, 16'h00F1, 0, 1, 1, 1);
    idle("R9");
    finish_run();
  end
endmodule